// File: doc/BRIEF.md
# Banked Digital I/O Controller with Edge Capture

This block provides 48 digital lines, grouped as six 8-bit ports, behind a byte-wide register bus. Each line behaves like an open-drain output. A 1 written to a port bit turns on the low-side driver for that pin. A 0 releases the pin, so it can be used as an input. A port read returns the complement of the synchronized pin level. With the usual pull-ups, a line that is released and idle therefore reads as 0.

The lower 24 lines (ports 0 to 2) can also capture edges. Each of these lines has three bits: one that picks the rising or the falling edge, one that enables capture, and one that latches a detected edge. These three banks share the same three bus offsets. The page field of a page/lock register selects which bank those offsets reach. Software finds captured edges in the pending summary, reads them through the capture bank, and clears them by writing zeros. A single interrupt output is asserted while any captured bit that is still enabled remains set.

Top module: `paged_dio_ctrl`

## Requirements
- R1: After reset, every output-enable bit and the interrupt output are 0, and the page/lock register reads 0.
- R2: A write to offset p (0 to 5) sets pin_oe_o[8p+7:8p] to the written byte. A 1 bit turns on the low-side driver for that pin.
- R3: A read of offset p (0 to 5) returns the bitwise complement of pin_i[8p+7:8p] after a two-flop synchronizer, so a high pin reads as 0.
- R4: Offset 7 holds a byte. Bits 7:6 are the page number and bits 5:0 are lock bits. The lock bits are stored and read back and have no other effect.
- R5: Offsets 8, 9 and 10 map to ports 0, 1 and 2. On page 1 they reach the edge-select registers, on page 2 the enable registers, and on page 3 the capture registers. On page 0 they read 0 and ignore writes.
- R6: Offsets 0 to 5 behave the same on every page.
- R7: An enabled line whose edge-select bit is 1 captures rising edges. An enabled line whose edge-select bit is 0 captures falling edges. The capture appears in the matching bit of the capture register.
- R8: A line whose enable bit is 0 captures no edge.
- R9: Offset 6 reads bit k (k = 0 to 2) as 1 when the capture register of port k is non-zero. Bits 7:3 read 0.
- R10: A write to a capture register clears each bit written as 0 and keeps each bit written as 1. An edge detected in the same cycle as the clearing write remains captured.
- R11: irq_o is 1 exactly when some capture bit is set and its enable bit is also set.
- R12: Offsets 11 to 15 read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register offset |
| wr_en_i | input | 1 | Write strobe for the current cycle |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for addr_i (combinational) |
| pin_i | input | 48 | Pin levels |
| pin_oe_o | output | 48 | Low-side driver enables |
| irq_o | output | 1 | Edge interrupt request |

## Verification
The assertions assume that addr_i and wr_data_i are stable while wr_en_i is high at a clock edge. They also assume that pin_i is a level that the synchronizer may resample.

The stimulus meets both assumptions. It changes bus signals and pins only on the falling clock edge, and it leaves four cycles after each pin change before checking capture state. One test deliberately places a clearing write on the exact edge where a new detection arrives, so that the hold-on-collision rule is exercised.

// File: rtl/dio_pkg.sv
package dio_pkg;
  typedef enum logic [1:0] {
    PG_NONE = 2'd0,
    PG_POL  = 2'd1,
    PG_ENA  = 2'd2,
    PG_EID  = 2'd3
  } page_e;

  localparam int ADDR_PEND  = 6;
  localparam int ADDR_PAGE  = 7;
  localparam int ADDR_BANK0 = 8;
endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dio_edge_port.sv
module dio_edge_port #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic         pol_wr_i,
  input  logic         ena_wr_i,
  input  logic         eid_wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] pol_o,
  output logic [W-1:0] ena_o,
  output logic [W-1:0] eid_o,
  output logic         irq_o
);
  logic [W-1:0] pol_q, ena_q, eid_q, prev_q;
  logic [W-1:0] rise, fall, hit;

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;
  assign hit  = ena_q & ((pol_q & rise) | (~pol_q & fall));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q  <= '0;
      ena_q  <= '0;
      eid_q  <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= lvl_i;
      if (pol_wr_i) pol_q <= wdata_i;
      if (ena_wr_i) ena_q <= wdata_i;
      // new detections win over a clearing write
      if (eid_wr_i) eid_q <= (eid_q & wdata_i) | hit;
      else          eid_q <= eid_q | hit;
    end
  end

  assign pol_o = pol_q;
  assign ena_o = ena_q;
  assign eid_o = eid_q;
  assign irq_o = |(eid_q & ena_q);

  assert_no_capture_disabled_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((eid_q & ~$past(eid_q) & ~$past(ena_q)) == '0));

  assert_clear_all_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eid_wr_i && wdata_i == '0 && hit == '0) |=> (eid_q == '0));
endmodule

// File: rtl/paged_dio_ctrl.sv
module paged_dio_ctrl
  import dio_pkg::*;
#(
  parameter int NUM_PORTS   = 6,
  parameter int PORT_W      = 8,
  parameter int EDGE_PORTS  = 3,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic                          wr_en_i,
  input  logic [PORT_W-1:0]             wr_data_i,
  output logic [PORT_W-1:0]             rd_data_o,
  input  logic [NUM_PORTS*PORT_W-1:0]   pin_i,
  output logic [NUM_PORTS*PORT_W-1:0]   pin_oe_o,
  output logic                          irq_o
);
  localparam int PINS = NUM_PORTS * PORT_W;

  logic [PORT_W-1:0] port_out_q [NUM_PORTS];
  logic [PORT_W-1:0] lvl_w      [NUM_PORTS];
  logic [PORT_W-1:0] pol_w      [EDGE_PORTS];
  logic [PORT_W-1:0] ena_w      [EDGE_PORTS];
  logic [PORT_W-1:0] eid_w      [EDGE_PORTS];
  logic [EDGE_PORTS-1:0] irq_e, pend;
  logic [PINS-1:0]   lvl_all;
  logic [PORT_W-1:0] page_q;
  page_e             cur_page;

  assign cur_page = page_e'(page_q[PORT_W-1 -: 2]);

  dio_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (lvl_all)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) page_q <= '0;
    else if (wr_en_i && addr_i == ADDR_W'(ADDR_PAGE)) page_q <= wr_data_i;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) port_out_q[p] <= '0;
      else if (wr_en_i && addr_i == ADDR_W'(p)) port_out_q[p] <= wr_data_i;
    end
    assign pin_oe_o[p*PORT_W +: PORT_W] = port_out_q[p];
    assign lvl_w[p] = lvl_all[p*PORT_W +: PORT_W];

    assert_port_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == ADDR_W'(p)) |=> (port_out_q[p] == $past(wr_data_i)));
  end

  for (genvar e = 0; e < EDGE_PORTS; e++) begin : g_edge
    logic sel;
    assign sel = wr_en_i && (addr_i == ADDR_W'(ADDR_BANK0 + e));

    dio_edge_port #(.W(PORT_W)) u_edge (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .lvl_i    (lvl_w[e]),
      .pol_wr_i (sel && cur_page == PG_POL),
      .ena_wr_i (sel && cur_page == PG_ENA),
      .eid_wr_i (sel && cur_page == PG_EID),
      .wdata_i  (wr_data_i),
      .pol_o    (pol_w[e]),
      .ena_o    (ena_w[e]),
      .eid_o    (eid_w[e]),
      .irq_o    (irq_e[e])
    );
    assign pend[e] = |eid_w[e];
  end

  always_comb begin
    rd_data_o = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (addr_i == ADDR_W'(p)) rd_data_o = ~lvl_w[p];
    if (addr_i == ADDR_W'(ADDR_PEND)) rd_data_o = PORT_W'(pend);
    if (addr_i == ADDR_W'(ADDR_PAGE)) rd_data_o = page_q;
    for (int e = 0; e < EDGE_PORTS; e++) begin
      if (addr_i == ADDR_W'(ADDR_BANK0 + e)) begin
        case (cur_page)
          PG_POL:  rd_data_o = pol_w[e];
          PG_ENA:  rd_data_o = ena_w[e];
          PG_EID:  rd_data_o = eid_w[e];
          default: rd_data_o = '0;
        endcase
      end
    end
  end

  assign irq_o = |irq_e;

  assert_irq_needs_pending_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend != '0));

  assert_page_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(ADDR_PAGE)) |=> (page_q == $past(wr_data_i)));
endmodule

// File: tb/paged_dio_ctrl_tb.sv
`timescale 1ns/1ps
module paged_dio_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [47:0] pins = '1;
  logic [47:0] oe;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int         kind;
    int         idx;
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;

  paged_dio_ctrl dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .addr_i    (addr),
    .wr_en_i   (wr_en),
    .wr_data_i (wdata),
    .rd_data_o (rdata),
    .pin_i     (pins),
    .pin_oe_o  (oe),
    .irq_o     (irq)
  );

  // monitor: compares queued expectations shortly after each falling edge
  always @(negedge clk) begin
    #2;
    while (sb_q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        0:       act = rdata;
        1:       act = {7'b0, irq};
        default: act = oe[it.idx*8 +: 8];
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d idx=%0d actual=%02h expected=%02h",
                 it.req, it.kind, it.idx, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic exp_rd(input logic [3:0] a, input logic [7:0] e, input string r);
    @(negedge clk);
    addr = a;
    sb_q.push_back('{0, 0, e, r});
    @(posedge clk);
  endtask

  task automatic exp_irq(input logic e, input string r);
    @(negedge clk);
    sb_q.push_back('{1, 0, {7'b0, e}, r});
    @(posedge clk);
  endtask

  task automatic exp_oe(input int p, input logic [7:0] e, input string r);
    @(negedge clk);
    sb_q.push_back('{2, p, e, r});
    @(posedge clk);
  endtask

  task automatic set_pins(input int p, input logic [7:0] v);
    @(negedge clk);
    pins[p*8 +: 8] = v;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    exp_irq(1'b0, "R1");
    exp_oe(0, 8'h00, "R1");
    exp_rd(4'd7, 8'h00, "R1");
    exp_rd(4'd0, 8'h00, "R3");

    wr(4'd2, 8'hA5);
    exp_oe(2, 8'hA5, "R2");
    wr(4'd5, 8'h3C);
    exp_oe(5, 8'h3C, "R2");

    set_pins(1, 8'h0F);
    exp_rd(4'd1, 8'hF0, "R3");

    wr(4'd7, 8'h95);
    exp_rd(4'd7, 8'h95, "R4");
    wr(4'd0, 8'h11);
    exp_oe(0, 8'h11, "R6");
    exp_rd(4'd4, 8'h00, "R6");
    exp_rd(4'd1, 8'hF0, "R6");

    // page 0: bank offsets inert
    wr(4'd7, 8'h00);
    wr(4'd8, 8'hFF);
    exp_rd(4'd8, 8'h00, "R5");
    wr(4'd7, 8'h40);
    exp_rd(4'd8, 8'h00, "R5");

    // port0: bit0 rising, bit1 falling; enable both; port1 disabled
    wr(4'd8, 8'h01);
    exp_rd(4'd8, 8'h01, "R5");
    wr(4'd7, 8'h80);
    wr(4'd8, 8'h03);
    wr(4'd9, 8'h00);
    exp_rd(4'd8, 8'h03, "R5");
    wr(4'd7, 8'hC0);
    exp_rd(4'd8, 8'h00, "R5");

    set_pins(0, 8'hFC);
    exp_rd(4'd8, 8'h02, "R7");
    exp_irq(1'b1, "R11");
    exp_rd(4'd6, 8'h01, "R9");

    wr(4'd8, 8'h00);
    exp_rd(4'd8, 8'h00, "R10");
    exp_irq(1'b0, "R11");
    exp_rd(4'd6, 8'h00, "R9");

    set_pins(0, 8'hFF);
    exp_rd(4'd8, 8'h01, "R7");

    set_pins(1, 8'h00);
    exp_rd(4'd9, 8'h00, "R8");
    exp_rd(4'd6, 8'h01, "R9");

    wr(4'd8, 8'h01);
    exp_rd(4'd8, 8'h01, "R10");
    wr(4'd8, 8'h00);
    exp_rd(4'd8, 8'h00, "R10");

    // falling edge on bit1 detected in the same cycle as a clearing write
    @(negedge clk) pins[1] = 1'b0;
    @(posedge clk);
    @(posedge clk);
    wr(4'd8, 8'h00);
    exp_rd(4'd8, 8'h02, "R10");
    exp_irq(1'b1, "R11");

    // disable port0: capture stays pending, interrupt masked
    wr(4'd7, 8'h80);
    wr(4'd8, 8'h00);
    exp_irq(1'b0, "R11");
    exp_rd(4'd6, 8'h01, "R9");

    wr(4'd12, 8'hFF);
    exp_rd(4'd12, 8'h00, "R12");
    exp_rd(4'd7, 8'h80, "R12");
    exp_oe(0, 8'h11, "R12");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule